// File: doc/BRIEF.md
# Multiplexed LCD Display RAM Loader

This block sits between a serial bus front end and a 24-word by 4-bit segment RAM. It accepts one display byte at a time and spreads its eight bits over several RAM words. The number of bits per word follows the multiplex mode: 1, 2, 3 or 4 rows per word. The first bit taken is the byte's most significant one. Within a word, rows fill upward from the lowest row in use. The block then moves on to the next word. It emits one RAM word write per clock cycle and holds `busy_o` high until the byte is fully spread.

A 5-bit write pointer selects the RAM word. A 3-bit cascade counter names the device in a chain that should receive the data. A write reaches the RAM port only when the cascade counter equals the hardware strap `hw_sub_i`. On a mismatch the words are skipped silently, but the pointer still moves. When the pointer passes the last word it returns to 0 and the cascade counter steps by one, even in the middle of a byte, so a chain of devices loads as a single long memory. In the one-row and two-row modes, a bank select redirects the data into the upper half of each word. This lets a second image be prepared without disturbing the one on display.

Top module: `lcd_ram_loader`

## Requirements
- R1: After reset the write pointer and the cascade counter are 0, `busy_o` is low and `wr_en_o` is low. The first byte written with `hw_sub_i`=0 starts at word 0.
- R2: With `mode_i`=0 (one row), a byte writes row 0 of 8 consecutive words. Word i carries byte bit 7-i in `wr_data_o[0]` with `wr_mask_o`=4'b0001. The pointer advances by 8.
- R3: With `mode_i`=1 (two rows), a byte writes 4 consecutive words. Word i gets byte bit 7-2i in row 0 and bit 6-2i in row 1, with mask 4'b0011. The pointer advances by 4.
- R4: With `mode_i`=2 (three rows), a byte writes 3 consecutive words. The first two carry three bits each in rows 0..2 (mask 4'b0111). The third carries byte bits 1 and 0 in rows 0 and 1, with mask 4'b0011 so that row 2 is left untouched. The pointer advances by 3.
- R5: With `mode_i`=3 (four rows), a byte writes 2 consecutive words. Rows 0..3 of the first word get bits 7..4 and rows 0..3 of the second get bits 3..0 (mask 4'b1111). The pointer advances by 2.
- R6: When the cascade counter differs from `hw_sub_i`, `wr_en_o` stays low for the whole byte, yet the pointer advances by the same stride as for a stored byte.
- R7: Stepping past word 23 returns the pointer to 0 and increments the cascade counter. This holds mid-byte; the rest of the byte continues at word 0 under the new counter value.
- R8: With `in_bank_i`=1, mode 0 writes row 2 (mask 4'b0100) and mode 1 writes rows 2 and 3 (mask 4'b1100). In modes 2 and 3 the bank select has no effect.
- R9: A pointer load with a value above 23 sets the pointer to 23.
- R10: Word writes occupy consecutive cycles starting one cycle after the byte is accepted, and `busy_o` is high for exactly those cycles. A byte strobe or a pointer or counter load presented while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_vld_i | input | 1 | Display byte strobe, taken when not busy |
| byte_i | input | 8 | Display byte |
| ptr_ld_i | input | 1 | Load write pointer, taken when not busy |
| ptr_val_i | input | 5 | Pointer load value (clamped to 23) |
| sub_ld_i | input | 1 | Load cascade counter, taken when not busy |
| sub_val_i | input | 3 | Cascade counter load value |
| mode_i | input | 2 | Rows per word minus one: 0 static, 1 two-row, 2 three-row, 3 four-row |
| in_bank_i | input | 1 | Upper-bank select for modes 0 and 1 |
| hw_sub_i | input | 3 | Hardware subaddress strap of this device |
| busy_o | output | 1 | A byte is being spread over RAM words |
| wr_en_o | output | 1 | RAM word write enable |
| wr_addr_o | output | 5 | RAM word address |
| wr_data_o | output | 4 | Row data, bit n is row n |
| wr_mask_o | output | 4 | Rows written, bit n is row n |

## Verification
Several properties are checked on every cycle: the pointer never leaves 0..23, the wrap carry into the cascade counter, writes appearing only while busy, a single row being written in mode 0, and the bank select keeping the lower rows clear. Only the bench scenarios can show which byte bit lands in which row and word, the address sequence across several bytes, and the skipped-but-advanced behaviour of a mismatched device. They also cover a byte straddling the wrap into the next cascade device, the load clamp, and stimulus being ignored while busy.

// File: rtl/lcd_ldr_pkg.sv
package lcd_ldr_pkg;
  typedef enum logic [1:0] {
    MODE_STATIC  = 2'd0,
    MODE_DUPLEX  = 2'd1,
    MODE_TRIPLEX = 2'd2,
    MODE_QUAD    = 2'd3
  } mux_mode_e;
endpackage

// File: rtl/lcd_ptr_ctr.sv
module lcd_ptr_ctr #(
  parameter int NUM_WORDS = 24,
  parameter int SUB_W     = 3,
  localparam int AW       = $clog2(NUM_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_ptr_i,
  input  logic [AW-1:0]    ptr_val_i,
  input  logic             ld_sub_i,
  input  logic [SUB_W-1:0] sub_val_i,
  input  logic             adv_i,
  output logic [AW-1:0]    ptr_o,
  output logic [SUB_W-1:0] sub_o
);
  localparam logic [AW-1:0] LAST = AW'(NUM_WORDS - 1);

  logic [AW-1:0]    ptr_q;
  logic [SUB_W-1:0] sub_q;
  logic             wrap;

  assign wrap = adv_i && (ptr_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      sub_q <= '0;
    end else begin
      if (ld_ptr_i)  ptr_q <= (ptr_val_i > LAST) ? LAST : ptr_val_i;
      else if (wrap) ptr_q <= '0;
      else if (adv_i) ptr_q <= ptr_q + AW'(1);

      if (ld_sub_i)  sub_q <= sub_val_i;
      else if (wrap) sub_q <= sub_q + SUB_W'(1);
    end
  end

  assign ptr_o = ptr_q;
  assign sub_o = sub_q;

  // R9
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST);

  // R7
  wrap_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !ld_ptr_i && !ld_sub_i) |=> (ptr_q == '0) && (sub_q == $past(sub_q) + SUB_W'(1)));
endmodule

// File: rtl/lcd_byte_slicer.sv
module lcd_byte_slicer
  import lcd_ldr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ROWS   = 4,
  localparam int CW    = $clog2(BYTE_W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  mux_mode_e       mode_i,
  input  logic            bank_i,
  output logic            active_o,
  output logic            last_o,
  output logic [ROWS-1:0] data_o,
  output logic [ROWS-1:0] mask_o
);
  logic [BYTE_W-1:0] sh_q;
  logic [CW-1:0]     left_q;
  mux_mode_e         mode_q;
  logic              bank_q;
  logic              active_q;

  logic [CW-1:0] per_word, take;
  int            base;

  always_comb begin
    per_word = CW'(mode_q) + CW'(1);
    take     = (left_q < per_word) ? left_q : per_word;
    base     = (bank_q && (mode_q == MODE_STATIC || mode_q == MODE_DUPLEX)) ? ROWS / 2 : 0;
    data_o   = '0;
    mask_o   = '0;
    for (int j = 0; j < ROWS; j++) begin
      if (active_q && (CW'(j) < take) && (base + j < ROWS)) begin
        mask_o[base+j] = 1'b1;
        data_o[base+j] = sh_q[BYTE_W-1-j];
      end
    end
  end

  assign last_o   = active_q && (left_q == take);
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      left_q   <= '0;
      mode_q   <= MODE_STATIC;
      bank_q   <= 1'b0;
      active_q <= 1'b0;
    end else if (active_q) begin
      sh_q   <= sh_q << take;
      left_q <= left_q - take;
      if (left_q == take) active_q <= 1'b0;
    end else if (start_i) begin
      sh_q     <= byte_i;
      left_q   <= CW'(BYTE_W);
      mode_q   <= mode_i;
      bank_q   <= bank_i;
      active_q <= 1'b1;
    end
  end

  // R2
  static_one_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && mode_q == MODE_STATIC) |-> ($countones(mask_o) == 1));

  // R8
  bank_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && bank_q && (mode_q == MODE_STATIC || mode_q == MODE_DUPLEX))
      |-> (mask_o[ROWS/2-1:0] == '0));

  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !last_o) |=> active_q);
endmodule

// File: rtl/lcd_ram_loader.sv
module lcd_ram_loader
  import lcd_ldr_pkg::*;
#(
  parameter int NUM_WORDS = 24,
  parameter int ROWS      = 4,
  parameter int BYTE_W    = 8,
  parameter int SUB_W     = 3,
  localparam int AW       = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ptr_ld_i,
  input  logic [AW-1:0]     ptr_val_i,
  input  logic              sub_ld_i,
  input  logic [SUB_W-1:0]  sub_val_i,
  input  logic [1:0]        mode_i,
  input  logic              in_bank_i,
  input  logic [SUB_W-1:0]  hw_sub_i,
  output logic              busy_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [ROWS-1:0]   wr_data_o,
  output logic [ROWS-1:0]   wr_mask_o
);
  logic             active, last;
  logic [AW-1:0]    ptr;
  logic [SUB_W-1:0] sub;

  lcd_ptr_ctr #(.NUM_WORDS(NUM_WORDS), .SUB_W(SUB_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_ptr_i  (ptr_ld_i & ~active),
    .ptr_val_i (ptr_val_i),
    .ld_sub_i  (sub_ld_i & ~active),
    .sub_val_i (sub_val_i),
    .adv_i     (active),
    .ptr_o     (ptr),
    .sub_o     (sub)
  );

  lcd_byte_slicer #(.BYTE_W(BYTE_W), .ROWS(ROWS)) u_slice (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (byte_vld_i),
    .byte_i   (byte_i),
    .mode_i   (mux_mode_e'(mode_i)),
    .bank_i   (in_bank_i),
    .active_o (active),
    .last_o   (last),
    .data_o   (wr_data_o),
    .mask_o   (wr_mask_o)
  );

  assign busy_o    = active;
  assign wr_en_o   = active && (sub == hw_sub_i);
  assign wr_addr_o = ptr;

  // R10
  write_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (busy_o && wr_mask_o != '0));

  // R10
  idle_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> !busy_o);
endmodule

// File: tb/sim_lcd_ram_loader.sv
`timescale 1ns/1ps
module sim_lcd_ram_loader;
  logic       clk = 0, rst_n = 0;
  logic       byte_vld = 0, ptr_ld = 0, sub_ld = 0, in_bank = 0;
  logic [7:0] byte_d = 0;
  logic [4:0] ptr_val = 0;
  logic [2:0] sub_val = 0, hw_sub = 0;
  logic [1:0] mode = 0;
  logic       busy, wr_en;
  logic [4:0] wr_addr;
  logic [3:0] wr_data, wr_mask;

  int checks = 0, errors = 0;
  int m_ptr = 0, m_sub = 0;
  logic [4:0] q_addr[$];
  logic [3:0] q_data[$], q_mask[$];
  string      q_tag[$];

  always #5 clk = ~clk;

  lcd_ram_loader u0 (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(byte_vld), .byte_i(byte_d),
    .ptr_ld_i(ptr_ld), .ptr_val_i(ptr_val), .sub_ld_i(sub_ld), .sub_val_i(sub_val),
    .mode_i(mode), .in_bank_i(in_bank), .hw_sub_i(hw_sub), .busy_o(busy),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_mask_o(wr_mask)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare each write
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (q_addr.size() == 0) check(0, "R6 unexpected write", int'(wr_addr), -1);
      else begin
        logic [4:0] ea; logic [3:0] ed, em; string t;
        ea = q_addr.pop_front(); ed = q_data.pop_front();
        em = q_mask.pop_front(); t = q_tag.pop_front();
        check(wr_addr == ea, {t, " addr"}, int'(wr_addr), int'(ea));
        check(wr_mask == em, {t, " mask"}, int'(wr_mask), int'(em));
        check((wr_data & em) == ed, {t, " data"}, int'(wr_data & em), int'(ed));
      end
    end
  end

  task automatic load(input bit dp, input int pv, input bit ds, input int sv);
    ptr_ld = dp; ptr_val = 5'(pv); sub_ld = ds; sub_val = 3'(sv);
    @(negedge clk);
    ptr_ld = 0; sub_ld = 0;
    if (dp) m_ptr = (pv > 23) ? 23 : pv;
    if (ds) m_sub = sv;
  endtask

  task automatic send(input logic [7:0] b, input int md, input bit bk, input string tag,
                      input bit poke = 0);
    int per = md + 1, left = 8, n = 0, cnt = 0, base;
    logic [7:0] sh = b;
    base = (bk && md <= 1) ? 2 : 0;
    while (left > 0) begin
      int k = (left < per) ? left : per;
      logic [3:0] em = 0, ed = 0;
      for (int j = 0; j < k; j++) begin
        em[base+j] = 1'b1; ed[base+j] = sh[7-j];
      end
      sh = sh << k; left -= k;
      if (m_sub[2:0] == hw_sub) begin
        q_addr.push_back(5'(m_ptr)); q_data.push_back(ed);
        q_mask.push_back(em); q_tag.push_back(tag);
      end
      m_ptr++; n++;
      if (m_ptr == 24) begin m_ptr = 0; m_sub = (m_sub + 1) % 8; end
    end
    mode = 2'(md); in_bank = bk; byte_d = b; byte_vld = 1;
    @(negedge clk);
    byte_vld = 0;
    while (busy) begin
      cnt++;
      if (poke && cnt == 1) begin
        byte_vld = 1; byte_d = 8'hFF; ptr_ld = 1; ptr_val = 5; sub_ld = 1; sub_val = 7;
      end
      @(negedge clk);
      byte_vld = 0; ptr_ld = 0; sub_ld = 0;
    end
    check(cnt == n, {tag, " R10 busy cycles"}, cnt, n);
    check(q_addr.size() == 0, {tag, " all words written"}, q_addr.size(), 0);
    q_addr.delete(); q_data.delete(); q_mask.delete(); q_tag.delete();
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(wr_en == 0, "R1 wr_en after reset", wr_en, 0);
    rst_n = 1;
    @(negedge clk);
    send(8'hA5, 0, 0, "R1 R2 static from word 0");
    send(8'h3C, 1, 0, "R3 two-row");
    send(8'hB7, 2, 0, "R4 three-row");
    send(8'h5A, 3, 0, "R5 four-row");
    load(1, 30, 0, 0);
    send(8'hF0, 3, 0, "R9 clamp R7 wrap");
    hw_sub = 1;
    send(8'h96, 0, 0, "R7 next device");
    load(0, 0, 1, 3);
    send(8'hC3, 1, 0, "R6 mismatch skip");
    load(0, 0, 1, 1);
    send(8'h69, 0, 0, "R6 pointer advanced");
    load(1, 0, 0, 0);
    send(8'h81, 0, 1, "R8 static bank1");
    send(8'hE4, 1, 1, "R8 two-row bank1");
    send(8'h1E, 3, 1, "R8 four-row bank ignored");
    send(8'h2D, 2, 1, "R8 three-row bank ignored");
    load(1, 22, 0, 0);
    send(8'hD2, 2, 0, "R7 mid-byte straddle");
    hw_sub = 2;
    send(8'h4B, 0, 0, "R7 remainder device");
    send(8'h77, 3, 0, "R10 poke while busy", 1);
    send(8'h8E, 1, 0, "R10 after poke");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule